// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address of each beat of a DRAM burst. A burst begins when the command logic pulses a start strobe. The start strobe carries the starting column, the read/write direction and the current contents of the mode word. The block decodes the length and ordering fields of that mode word and captures them for the rest of the burst.

From then on it presents one column per clock while the advance input is high, and holds the column while advance is low. Every fixed-length burst stays inside the aligned group of columns picked by the upper address bits. A page-length burst walks the whole row and wraps until it is cut short.

A last-beat flag marks the final beat, so the command logic knows when the column stream ends. The flag is also raised at once when a terminate request arrives. A configuration error flag reports a mode word whose length code is not defined.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held, and on the first cycle after its release, `beatValid`, `lastBeat` and `cfgError` are 0.
- R2: On the clock edge after `startValid` is high, `beatValid` is 1 and `colAddr` equals the `startCol` given with the start. Ordering and length have no effect on this first beat.
- R3: Sequential order is selected by mode bit 3 = 0. Beat k of a burst of length L is `(startCol & ~(L-1)) | ((startCol + k) mod L)`. Example: start index 5 of 8 gives 5,6,7,0,1,2,3,4.
- R4: Interleaved order is selected by mode bit 3 = 1. Beat k is `(startCol & ~(L-1)) | ((startCol ^ k) & (L-1))`. Example: start index 5 of 8 gives 5,4,7,6,1,0,3,2.
- R5: The length code sits in mode bits 2:0. Codes 000, 001, 010 and 011 give 1, 2, 4 and 8 beats. `lastBeat` is 1 exactly on beat L-1. An advance on that beat makes `beatValid` 0 on the next edge.
- R6: For length code 000, mode bit 3 has no effect, and the single beat is `startCol`.
- R7: Code 111 with mode bit 3 = 0 selects a page burst. It steps sequentially through all 2^COL_W columns, wraps from the top column to column 0, and never raises `lastBeat` on its own.
- R8: `terminate` during an active burst raises `lastBeat` in that same cycle. `beatValid` is 0 after the next edge, whether or not `advance` is high.
- R9: When mode bit 9 = 1 and `startIsWrite` = 1, the burst is one beat long. A read with the same mode word uses the programmed length.
- R10: A reserved length code gives a one-beat burst and sets `cfgError` = 1 from the next edge until the next start. The reserved codes are 100, 101 and 110, and 111 with mode bit 3 = 1. A start with a defined code clears `cfgError`.
- R11: While `advance` and `terminate` are both low, `colAddr`, `beatValid` and `lastBeat` keep their values.
- R12: A `startValid` during an active burst abandons that burst and starts the new one on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| modeWord | input | MODE_W | Mode word sampled at start: bits 2:0 length, bit 3 order, bit 9 single-beat writes |
| startValid | input | 1 | Begin a new burst |
| startIsWrite | input | 1 | The burst being started is a write |
| startCol | input | COL_W | Starting column of the burst |
| advance | input | 1 | Move to the next beat |
| terminate | input | 1 | Stop the burst after the current beat |
| colAddr | output | COL_W | Column address of the current beat |
| beatValid | output | 1 | A burst beat is being presented |
| lastBeat | output | 1 | Current beat is the final one |
| cfgError | output | 1 | The last start used a reserved length code |

## Verification
On every cycle, the embedded properties check four things. The first beat repeats the start column. A sequential step adds one modulo the burst length, and an interleaved step changes exactly the bits that flip in the beat counter. A stall freezes the column. Termination, a last beat taken with advance, and restarts move `beatValid` as required, and the error flag follows the decoded code.

Only the bench scenarios can show the complete address sequences for each length and order. They also cover the page wrap from the top column, the write-only single-beat override, and the way a reserved code collapses to one beat.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  // Field positions in the mode word; neighbours decode the same layout.
  localparam int LEN_LSB     = 0;
  localparam int LEN_W       = 3;
  localparam int TYPE_BIT    = 3;
  localparam int WSINGLE_BIT = 9;

  typedef enum logic [LEN_W-1:0] {
    LEN_ONE   = 3'b000,
    LEN_TWO   = 3'b001,
    LEN_FOUR  = 3'b010,
    LEN_EIGHT = 3'b011,
    LEN_PAGE  = 3'b111
  } lenCode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;
    logic step;
  } dpCtl_t;

endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
  import burst_col_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MODE_W = 12
) (
  input  logic [MODE_W-1:0] modeWord,
  input  logic              isWrite,
  output logic [COL_W-1:0]  lenMask,
  output logic              interleave,
  output logic              fullPage,
  output logic              cfgErr
);

  logic [LEN_W-1:0] code;
  logic             typeBit;
  logic             singleWr;
  logic [COL_W-1:0] progMask;
  logic             codeOk;
  logic             pageSel;

  always_comb begin
    code     = modeWord[LEN_LSB +: LEN_W];
    typeBit  = modeWord[TYPE_BIT];
    singleWr = isWrite & modeWord[WSINGLE_BIT];
    progMask = '0;
    codeOk   = 1'b0;
    pageSel  = 1'b0;
    case (code)
      LEN_ONE, LEN_TWO, LEN_FOUR, LEN_EIGHT: begin
        progMask = COL_W'((32'd1 << code) - 32'd1);
        codeOk   = 1'b1;
      end
      LEN_PAGE: begin
        if (!typeBit) begin
          progMask = '1;
          codeOk   = 1'b1;
          pageSel  = 1'b1;
        end
      end
      default: begin
        progMask = '0;
      end
    endcase
    lenMask    = singleWr ? '0 : progMask;
    fullPage   = pageSel & ~singleWr;
    interleave = typeBit & (lenMask != '0) & ~fullPage;
    cfgErr     = ~codeOk;
  end

endmodule

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startValid,
  input  logic   advance,
  input  logic   terminate,
  input  logic   atEnd,
  input  logic   decFullPage,
  input  logic   decErr,
  output dpCtl_t ctl,
  output logic   beatValid,
  output logic   lastBeat,
  output logic   cfgError
);

  logic active;
  logic pageR;
  logic errR;
  logic finish;

  always_comb begin
    lastBeat  = active & (terminate | (~pageR & atEnd));
    finish    = lastBeat & (advance | terminate);
    ctl.load  = startValid;
    ctl.step  = active & advance & ~lastBeat & ~startValid;
    beatValid = active;
    cfgError  = errR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      pageR  <= 1'b0;
      errR   <= 1'b0;
    end else if (startValid) begin
      active <= 1'b1;
      pageR  <= decFullPage;
      errR   <= decErr;
    end else if (finish) begin
      active <= 1'b0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (!beatValid && !cfgError));

  assert_restart_R12: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> beatValid);

  assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && lastBeat && advance && !startValid) |=> !beatValid);

  assert_term_stops_R8: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && terminate && !startValid) |=> !beatValid);

  assert_page_runs_R7: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && pageR && !terminate && !startValid) |=> beatValid);

  assert_err_capture_R10: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> (cfgError == $past(decErr)));

endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [COL_W-1:0] startCol,
  input  logic [COL_W-1:0] decMask,
  input  logic             decIlv,
  output logic [COL_W-1:0] colAddr,
  output logic             atEnd
);

  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] beatCnt;
  logic [COL_W-1:0] maskR;
  logic             ilvR;
  logic [COL_W-1:0] offset;

  always_comb begin
    offset  = ilvR ? (baseCol ^ beatCnt) : (baseCol + beatCnt);
    colAddr = (baseCol & ~maskR) | (offset & maskR);
    atEnd   = (beatCnt == maskR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCol <= '0;
      beatCnt <= '0;
      maskR   <= '0;
      ilvR    <= 1'b0;
    end else if (ctl.load) begin
      baseCol <= startCol;
      beatCnt <= '0;
      maskR   <= decMask;
      ilvR    <= decIlv;
    end else if (ctl.step) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (colAddr == $past(startCol)));

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ilvR) |=>
      (((colAddr - $past(colAddr)) & $past(maskR)) == COL_W'(1)));

  assert_ilv_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && ilvR) |=>
      ((colAddr ^ $past(colAddr)) ==
       (($past(beatCnt) ^ ($past(beatCnt) + 1'b1)) & $past(maskR))));

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.step) |=> $stable(colAddr));

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              startValid,
  input  logic              startIsWrite,
  input  logic [COL_W-1:0]  startCol,
  input  logic              advance,
  input  logic              terminate,
  output logic [COL_W-1:0]  colAddr,
  output logic              beatValid,
  output logic              lastBeat,
  output logic              cfgError
);

  logic [COL_W-1:0] decMask;
  logic             decIlv;
  logic             decFullPage;
  logic             decErr;
  logic             atEnd;
  dpCtl_t           ctl;

  burst_mode_decode #(.COL_W(COL_W), .MODE_W(MODE_W)) u_decode (
    .modeWord  (modeWord),
    .isWrite   (startIsWrite),
    .lenMask   (decMask),
    .interleave(decIlv),
    .fullPage  (decFullPage),
    .cfgErr    (decErr)
  );

  burst_col_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .advance    (advance),
    .terminate  (terminate),
    .atEnd      (atEnd),
    .decFullPage(decFullPage),
    .decErr     (decErr),
    .ctl        (ctl),
    .beatValid  (beatValid),
    .lastBeat   (lastBeat),
    .cfgError   (cfgError)
  );

  burst_col_dp #(.COL_W(COL_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .startCol(startCol),
    .decMask (decMask),
    .decIlv  (decIlv),
    .colAddr (colAddr),
    .atEnd   (atEnd)
  );

endmodule

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/1ps
module burst_col_gen_tb;
  localparam int COL_W  = 9;
  localparam int MODE_W = 12;
  localparam int PAGE   = 1 << COL_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic [MODE_W-1:0] modeWord;
  logic              startValid;
  logic              startIsWrite;
  logic [COL_W-1:0]  startCol;
  logic              advance;
  logic              terminate;
  logic [COL_W-1:0]  colAddr;
  logic              beatValid;
  logic              lastBeat;
  logic              cfgError;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state, derived from the requirements.
  bit mAct, mFull, mIlv, mErr;
  int mK, mStart, mMask;

  always #2.5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W), .MODE_W(MODE_W)) u_dut (
    .clk(clk), .rstN(rstN), .modeWord(modeWord), .startValid(startValid),
    .startIsWrite(startIsWrite), .startCol(startCol), .advance(advance),
    .terminate(terminate), .colAddr(colAddr), .beatValid(beatValid),
    .lastBeat(lastBeat), .cfgError(cfgError)
  );

  function automatic int expAddr();
    int off;
    off = mIlv ? (mStart ^ mK) : (mStart + mK);
    return (mStart & ~mMask & (PAGE - 1)) | (off & mMask);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chkOut(input string tag);
    chk(tag, "beatValid", int'(beatValid), int'(mAct));
    if (mAct) begin
      chk(tag, "colAddr", int'(colAddr), expAddr());
      chk(tag, "lastBeat", int'(lastBeat),
          int'(terminate || (!mFull && mK == mMask)));
    end
    chk(tag, "cfgError", int'(cfgError), int'(mErr));
  endtask

  task automatic modelStep();
    int  code;
    bit  m3, ok, last;
    if (startValid) begin
      code = int'(modeWord[2:0]);
      m3   = modeWord[3];
      ok   = (code < 4) || (code == 7 && !m3);
      mMask = (code < 4) ? ((1 << code) - 1) : ((code == 7 && !m3) ? PAGE - 1 : 0);
      mFull = (code == 7 && !m3);
      if (startIsWrite && modeWord[9]) begin
        mMask = 0;
        mFull = 0;
      end
      mIlv   = m3 && mMask != 0;
      mErr   = !ok;
      mAct   = 1;
      mK     = 0;
      mStart = int'(startCol);
    end else if (mAct) begin
      last = terminate || (!mFull && mK == mMask);
      if (last && (advance || terminate)) mAct = 0;
      else if (advance) mK = (mK + 1) % PAGE;
    end
  endtask

  task automatic cycle(input bit sv, input bit wr, input logic [MODE_W-1:0] md,
                       input int col, input bit adv, input bit term, input string tag);
    startValid   = sv;
    startIsWrite = wr;
    modeWord     = md;
    startCol     = COL_W'(col);
    advance      = adv;
    terminate    = term;
    #1;
    chkOut(tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic burst(input logic [MODE_W-1:0] md, input bit wr, input int col,
                       input int maxBeats, input string tag);
    int n;
    n = 0;
    cycle(1, wr, md, col, 0, 0, tag);
    while (mAct && n < maxBeats) begin
      cycle(0, 0, 0, 0, 1, 0, tag);
      n++;
    end
    if (mAct) cycle(0, 0, 0, 0, 0, 1, tag);
    cycle(0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    rstN = 0; modeWord = 0; startValid = 0; startIsWrite = 0;
    startCol = 0; advance = 0; terminate = 0;
    repeat (3) @(negedge clk);
    // R1: idle outputs under reset
    chk("R1", "beatValid", int'(beatValid), 0);
    chk("R1", "lastBeat", int'(lastBeat), 0);
    chk("R1", "cfgError", int'(cfgError), 0);
    rstN = 1;
    cycle(0, 0, 0, 0, 1, 1, "R1");

    burst(12'h003, 0, 45, 20, "R3");     // R2 first beat, R3 sequential 5..4 in block 40
    burst(12'h00B, 0, 45, 20, "R4");     // R4 interleaved 5-4-7-6-1-0-3-2
    burst(12'h000, 0, 45, 20, "R5");
    burst(12'h001, 0, 45, 20, "R5");
    burst(12'h002, 0, 46, 20, "R5");
    burst(12'h00A, 0, 47, 20, "R4");
    burst(12'h008, 0, 45, 20, "R6");     // length one ignores order bit
    burst(12'h007, 0, 508, 520, "R7");   // page wrap 511 -> 0, ended by terminate

    // R8: terminate mid burst, with and without advance
    cycle(1, 0, 12'h003, 16, 0, 0, "R8");
    cycle(0, 0, 0, 0, 1, 0, "R8");
    cycle(0, 0, 0, 0, 0, 1, "R8");
    cycle(0, 0, 0, 0, 0, 0, "R8");
    cycle(1, 0, 12'h00B, 19, 0, 0, "R8");
    cycle(0, 0, 0, 0, 1, 1, "R8");
    cycle(0, 0, 0, 0, 0, 0, "R8");

    burst(12'h203, 1, 45, 20, "R9");     // single-beat write
    burst(12'h203, 0, 45, 20, "R9");     // read keeps length 8
    burst(12'h004, 0, 45, 20, "R10");
    burst(12'h00F, 0, 45, 20, "R10");
    burst(12'h006, 0, 45, 20, "R10");
    burst(12'h001, 0, 45, 20, "R10");    // valid code clears flag

    // R11: stall holds the beat
    cycle(1, 0, 12'h002, 33, 0, 0, "R11");
    cycle(0, 0, 0, 0, 1, 0, "R11");
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0, 0, 0, "R11");
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0, 1, 0, "R11");

    // R12: restart replaces a burst in progress
    cycle(1, 0, 12'h003, 60, 0, 0, "R12");
    cycle(0, 0, 0, 0, 1, 0, "R12");
    cycle(1, 0, 12'h009, 99, 1, 0, "R12");
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0, 1, 0, "R12");

    // Random mix of modes, stalls, terminates and restarts
    for (int b = 0; b < 300; b++) begin
      logic [MODE_W-1:0] md;
      md = '0;
      md[2:0] = 3'($urandom % 8);
      md[3]   = 1'($urandom % 2);
      md[9]   = 1'($urandom % 2);
      cycle(1, 1'($urandom % 2), md, int'($urandom % PAGE), 0, 0, "R3/R4 random");
      for (int c = 0; c < 40 && mAct; c++) begin
        if ($urandom % 50 == 0) begin
          md[2:0] = 3'($urandom % 4);
          cycle(1, 0, md, int'($urandom % PAGE), 1, 0, "R12 random");
        end else begin
          cycle(0, 0, 0, 0, 1'($urandom % 4 != 0), 1'($urandom % 40 == 0), "R5 random");
        end
      end
      if (mAct) cycle(0, 0, 0, 0, 0, 1, "R8 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule